// File: doc/BRIEF.md
# Receive Byte Queue with Fill-Level Interrupt

This block sits between the receive shift stage of a serial port and the CPU read path. Each assembled byte arrives with a one-cycle push strobe and is stored in a four-entry first-in first-out queue. The CPU side always sees the oldest stored byte on its read port and removes it with a pop strobe. The current occupancy is reported on its own output.

A two-bit level code, written through a write strobe, sets how many stored bytes raise the buffer-full interrupt request. Code values 0 to 3 select levels of 1 to 4 bytes. The request follows the occupancy: it is high while enough bytes are waiting and low as soon as reads bring the count below the level.

A byte pushed into a full queue with no read in the same cycle is lost, and a sticky overrun flag records the loss until software clears it with a strobe. Dropping the receive-enable input empties the queue.

Top module: `rx_fifo_thresh`

## Requirements
- R1: The queue holds up to 4 bytes, and `occupancy_o` reports the number stored (0 to 4) in the cycle after each push or pop edge.
- R2: A cycle with `lvl_we_i` high captures `lvl_code_i`. Code c selects an interrupt level of c+1 stored bytes, so codes 0, 1, 2 and 3 mean 1, 2, 3 and 4 bytes.
- R3: After reset the queue is empty, `overrun_o` is 0 and the level code is 0, so a single stored byte raises `irq_o`.
- R4: `irq_o` is 1 exactly when the occupancy is at or above the selected level. It falls in the cycle a pop brings the occupancy below the level.
- R5: `pop_data_o` shows the oldest stored byte whenever the occupancy is nonzero. A pop removes that byte, so bytes leave in arrival order.
- R6: A push while 4 bytes are stored and no pop is requested drops the byte and sets `overrun_o`. The flag stays set until a cycle with `ovr_clr_i` high clears it.
- R7: A pop while the queue is empty changes neither the occupancy nor the order of later bytes.
- R8: While `rx_en_i` is 0, the queue is flushed to occupancy 0 and pushes are ignored. `overrun_o` is not affected by the flush.
- R9: A push and a pop accepted in the same cycle leave the occupancy unchanged. This includes a full queue, where the incoming byte is accepted and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable; low flushes the queue |
| push_i | input | 1 | Byte-valid strobe from the shift stage |
| push_data_i | input | 8 | Received byte |
| pop_i | input | 1 | Read strobe from the bus side |
| pop_data_o | output | 8 | Oldest stored byte |
| lvl_we_i | input | 1 | Level code write strobe |
| lvl_code_i | input | 2 | Level code, level = code + 1 |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| occupancy_o | output | 3 | Number of stored bytes |
| overrun_o | output | 1 | Sticky lost-byte flag |
| irq_o | output | 1 | Buffer-full interrupt request |

## Verification
A read pointer that slips shows up on `pop_data_o` at the very next pop, as a byte that is out of order or repeated. A wrong occupancy count shows up one cycle later on `occupancy_o`, and it also moves the edges of `irq_o` relative to the level. A write pointer that advances on a dropped or disabled push only shows up when the stale slot is read, up to four pops later, which is why the bench drains the queue after every overrun and every flush. An overrun flag set or cleared at the wrong time is visible on `overrun_o` in the cycle after the push or the clear.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Interrupt fill level selected by a level code.
  function automatic int unsigned code_to_level(input int unsigned code);
    return code + 1;
  endfunction

  // Occupancy after one cycle of accepted push/pop.
  function automatic int unsigned next_occ(input int unsigned occ, input logic inc,
                                           input logic dec);
    return occ + (inc ? 1 : 0) - (dec ? 1 : 0);
  endfunction

  // Ring pointer advance with explicit wrap.
  function automatic int unsigned ring_next(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data
);
  import rxq_pkg::*;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] slot_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (flush) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_en) wr_ptr_q <= AW'(ring_next(int'(wr_ptr_q), DEPTH));
      if (rd_en) rd_ptr_q <= AW'(ring_next(int'(rd_ptr_q), DEPTH));
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (wr_en && !flush && (wr_ptr_q == AW'(g))) slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_ptr_q];
endmodule

// File: rtl/rxq_occ.sv
module rxq_occ #(
  parameter int DEPTH = 4,
  parameter int LW    = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          inc,
  input  logic          dec,
  input  logic          lvl_we,
  input  logic [LW-1:0] lvl_code,
  output logic [CW-1:0] occ,
  output logic          irq
);
  import rxq_pkg::*;

  logic [LW-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ <= '0;
    else if (flush)  occ <= '0;
    else             occ <= CW'(next_occ(int'(occ), inc, dec));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (lvl_we) code_q <= lvl_code;
  end

  assign irq = (int'(occ) >= int'(code_to_level(int'(code_q))));
endmodule

// File: rtl/rxq_ovr.sv
module rxq_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/rx_fifo_thresh.sv
module rx_fifo_thresh #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int LW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  input  logic          lvl_we_i,
  input  logic [LW-1:0] lvl_code_i,
  input  logic          ovr_clr_i,
  output logic [CW-1:0] occupancy_o,
  output logic          overrun_o,
  output logic          irq_o
);
  // Internal events, named for the checker.
  logic flush_evt, is_full, is_empty, push_ok, pop_ok, ovr_evt;

  assign flush_evt = !rx_en_i;
  assign is_full   = (occupancy_o == CW'(DEPTH));
  assign is_empty  = (occupancy_o == '0);
  assign pop_ok    = rx_en_i && pop_i && !is_empty;
  assign push_ok   = rx_en_i && push_i && (!is_full || pop_ok);
  assign ovr_evt   = rx_en_i && push_i && is_full && !pop_ok;

  rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush_evt),
    .wr_en(push_ok), .wr_data(push_data_i),
    .rd_en(pop_ok), .rd_data(pop_data_o)
  );

  rxq_occ #(.DEPTH(DEPTH), .LW(LW), .CW(CW)) u_occ (
    .clk(clk), .rst_n(rst_n), .flush(flush_evt),
    .inc(push_ok), .dec(pop_ok),
    .lvl_we(lvl_we_i), .lvl_code(lvl_code_i),
    .occ(occupancy_o), .irq(irq_o)
  );

  rxq_ovr u_ovr (
    .clk(clk), .rst_n(rst_n), .set(ovr_evt), .clr(ovr_clr_i), .flag(overrun_o)
  );
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en_i,
  input logic          push_i,
  input logic          pop_i,
  input logic          ovr_clr_i,
  input logic [CW-1:0] occupancy_o,
  input logic          overrun_o,
  input logic          irq_o
);
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy_o <= CW'(DEPTH)); // R1
  AST_IRQ_LOW_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy_o == '0) |-> !irq_o); // R4
  AST_IRQ_HIGH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy_o == CW'(DEPTH)) |-> irq_o); // R4
  AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en_i && push_i && !pop_i && occupancy_o == CW'(DEPTH)) |=> overrun_o); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && !ovr_clr_i) |=> overrun_o); // R6
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en_i && pop_i && !push_i && occupancy_o == '0) |=> (occupancy_o == '0)); // R7
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |=> (occupancy_o == '0)); // R8
  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en_i && push_i && pop_i && occupancy_o != '0) |=> $stable(occupancy_o)); // R9
endmodule

bind rx_fifo_thresh rxq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en_i), .push_i(push_i), .pop_i(pop_i),
  .ovr_clr_i(ovr_clr_i), .occupancy_o(occupancy_o), .overrun_o(overrun_o), .irq_o(irq_o)
);

// File: tb/tb_rx_fifo_thresh.sv
`timescale 1ns/100ps
module tb_rx_fifo_thresh;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b1, push = 1'b0, pop = 1'b0, lvl_we = 1'b0, ovr_clr = 1'b0;
  logic [7:0] pdata = '0;
  logic [1:0] lvl_code = '0;
  logic [7:0] pop_data;
  logic [2:0] occ;
  logic       ovr, irq;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  int  exp_code = 0;
  bit  exp_ovr = 0, exp_pop = 0, done = 0;

  always #2.5 clk = ~clk;

  rx_fifo_thresh dut (
    .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en), .push_i(push), .push_data_i(pdata),
    .pop_i(pop), .pop_data_o(pop_data), .lvl_we_i(lvl_we), .lvl_code_i(lvl_code),
    .ovr_clr_i(ovr_clr), .occupancy_o(occ), .overrun_o(ovr), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_state();
    chk("R1 occupancy", int'(occ), exp_q.size());
    chk("R4 irq", int'(irq), (exp_q.size() >= exp_code + 1) ? 1 : 0);
    chk("R6 overrun", int'(ovr), int'(exp_ovr));
  endtask

  // Monitor: compares the read port with the scoreboard head on accepted pops (R5).
  always @(negedge clk) begin
    if (exp_pop) begin
      chk("R5 pop data", int'(pop_data), int'(exp_q[0]));
      void'(exp_q.pop_front());
    end
  end

  // Driver: one cycle of push/pop, scoreboard updated from the requirements.
  task automatic cyc(input bit ps, input logic [7:0] d, input bit pp);
    int  sz = exp_q.size();
    bit  pok = rx_en && pp && sz > 0;
    bit  wok = rx_en && ps && (sz < 4 || pok);
    push = ps; pdata = d; pop = pp;
    if (rx_en && ps && sz == 4 && !pp) exp_ovr = 1;
    if (!rx_en) exp_q.delete();
    exp_pop = pok;
    if (wok) exp_q.push_back(d);
    @(posedge clk); #1;
    push = 0; pop = 0; exp_pop = 0;
    check_state();
  endtask

  task automatic set_level(input int code);
    lvl_we = 1; lvl_code = 2'(code);
    @(posedge clk); #1;
    lvl_we = 0; exp_code = code;
    check_state();
  endtask

  task automatic clear_ovr();
    ovr_clr = 1;
    @(posedge clk); #1;
    ovr_clr = 0; exp_ovr = 0;
    check_state();
  endtask

  task automatic drain();
    while (exp_q.size() > 0) cyc(0, 8'h00, 1);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R3: reset state
    chk("R3 occupancy after reset", int'(occ), 0);
    chk("R3 overrun after reset", int'(ovr), 0);
    chk("R3 irq after reset", int'(irq), 0);
    // R3: default level code 0 -> one byte raises irq
    cyc(1, 8'hA5, 0);
    chk("R3 irq at one byte with default code", int'(irq), 1);
    drain();

    // R2 / R4: every level code, fill and drain one byte at a time
    for (int c = 0; c < 4; c++) begin
      set_level(c);
      for (int k = 0; k < 4; k++) cyc(1, 8'(16 * c + k + 1), 0);
      for (int k = 0; k < 4; k++) cyc(0, 8'h00, 1);
    end

    // R4: irq falls when a pop goes below the level (code 2 -> 3 bytes)
    set_level(2);
    for (int k = 0; k < 3; k++) cyc(1, 8'(8'h30 + k), 0);
    chk("R4 irq at level", int'(irq), 1);
    cyc(0, 8'h00, 1);
    chk("R4 irq below level", int'(irq), 0);
    drain();
    set_level(0);

    // R6: overrun on a full push, byte dropped, flag sticky until cleared
    for (int k = 0; k < 4; k++) cyc(1, 8'(8'h40 + k), 0);
    cyc(1, 8'hEE, 0);
    chk("R6 overrun set", int'(ovr), 1);
    cyc(0, 8'h00, 0);
    chk("R6 overrun sticky", int'(ovr), 1);
    drain();
    clear_ovr();
    chk("R6 overrun cleared", int'(ovr), 0);

    // R7: pops on empty are ignored, order intact afterwards
    cyc(0, 8'h00, 1);
    cyc(0, 8'h00, 1);
    chk("R7 occupancy after empty pops", int'(occ), 0);
    cyc(1, 8'h5A, 0);
    cyc(1, 8'h5B, 0);
    drain();

    // R9: push and pop together, mid-fill and full
    cyc(1, 8'h61, 0);
    cyc(1, 8'h62, 0);
    cyc(1, 8'h63, 1);
    chk("R9 occupancy held at 2", int'(occ), 2);
    cyc(1, 8'h64, 0);
    cyc(1, 8'h65, 0);
    cyc(1, 8'h66, 1);
    chk("R9 occupancy held at full", int'(occ), 4);
    chk("R9 no overrun on full push+pop", int'(ovr), 0);
    // push+pop on empty: pop ignored, push taken
    drain();
    cyc(1, 8'h67, 1);
    chk("R9 push with empty pop", int'(occ), 1);
    drain();

    // R8: flush by receive enable, pushes ignored while disabled, overrun kept
    for (int k = 0; k < 4; k++) cyc(1, 8'(8'h70 + k), 0);
    cyc(1, 8'h7F, 0);
    rx_en = 0;
    cyc(0, 8'h00, 0);
    chk("R8 flushed", int'(occ), 0);
    cyc(1, 8'h80, 0);
    chk("R8 push ignored while disabled", int'(occ), 0);
    chk("R8 overrun kept", int'(ovr), 1);
    rx_en = 1;
    cyc(1, 8'h81, 0);
    cyc(1, 8'h82, 0);
    drain();
    clear_ovr();

    report();
  end
endmodule